// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Generator

This block keeps the 32-bit hypervisor control word of a virtual CPU interrupt interface. It raises one level-sensitive maintenance interrupt toward the hypervisor. The interrupt is built from several separately enabled conditions:

- how many list-register entries are currently valid;
- whether any entry is pending;
- whether the count of outstanding deactivates is nonzero;
- the state of the two virtual group enables.

A single global enable bit gates all of these conditions. A deactivate that finds no matching list entry arrives as a one-cycle pulse and advances a saturating five-bit counter held in the top of the word. Four trap-control bits of the word are driven out as plain wires for the trap logic that sits next to the block.

Software loads the whole word through a simple write strobe and reads it back continuously. Writing a value with a zero count field is how the counter is cleared. The list-register storage, trap handling and any bus protocol belong to neighbouring blocks.

Top module: `vmaint_gen`

## Requirements
- R1: After reset `rd_data` reads 0 and `maint_irq` is low.
- R2: A write stores `wr_data & 32'hF800_5CFF`. Bits [26:15], bit 13 and bits [9:8] always read 0, whatever was written to them.
- R3: In each cycle, `maint_irq` equals the value computed at the previous clock edge from the register contents and inputs at that edge. That value is bit 0 ANDed with the OR of the enabled conditions in R4 to R7. When bit 0 is 0, `maint_irq` is low in the next cycle.
- R4: With bit 1 set, the condition is true while `entry_valid` has zero or one bits set.
- R5: With bit 2 set, the condition is true while the count field [31:27] is nonzero.
- R6: With bit 3 set, the condition is true while `entry_pending` is all zeros.
- R7: The group conditions are as follows. Bit 4 is true while `vgrp0_en` is 1, and bit 5 while it is 0. Bit 6 is true while `vgrp1_en` is 1, and bit 7 while it is 0.
- R8: A `deact_pulse` with no write adds 1 to the count field [31:27], and the count stays at 31 once it reaches 31.
- R9: When `wr_en` and `deact_pulse` are both high in the same cycle, the written value is loaded and the pulse is dropped.
- R10: The trap outputs follow register bits: `trap_common` follows bit 10, `trap_grp0` bit 11, `trap_grp1` bit 12 and `trap_deact` bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register contents |
| entry_valid | input | N_ENTRIES | Valid flag per list entry |
| entry_pending | input | N_ENTRIES | Pending flag per list entry |
| vgrp0_en | input | 1 | Virtual group 0 enable state |
| vgrp1_en | input | 1 | Virtual group 1 enable state |
| deact_pulse | input | 1 | Deactivate that found no entry |
| maint_irq | output | 1 | Registered maintenance interrupt |
| trap_common | output | 1 | Trap control for common registers |
| trap_grp0 | output | 1 | Trap control for group 0 registers |
| trap_grp1 | output | 1 | Trap control for group 1 registers |
| trap_deact | output | 1 | Trap control for deactivate writes |

## Verification
A software write and a deactivate pulse can arrive in the same cycle, and both target the count field. The bench drives these collisions deliberately, including one at saturation and one with a nonzero write value, and expects the written count with no extra increment. The interrupt also depends on the count that a pulse has just changed, so a pulse that sets the count from 0 to 1 is checked to raise the interrupt one cycle after the register changes. Both cases are judged against a reference model that is compared on every clock.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;
  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned CNT_W   = 5;
  localparam int unsigned CNT_LSB = 27;
  localparam int unsigned CNT_MSB = CNT_LSB + CNT_W - 1;

  // control bit positions
  localparam int unsigned B_EN        = 0;
  localparam int unsigned B_UNDERFLOW = 1;
  localparam int unsigned B_CNT_NZ    = 2;
  localparam int unsigned B_NOPEND    = 3;
  localparam int unsigned B_G0_ON     = 4;
  localparam int unsigned B_G0_OFF    = 5;
  localparam int unsigned B_G1_ON     = 6;
  localparam int unsigned B_G1_OFF    = 7;
  localparam int unsigned B_TRAP_CMN  = 10;
  localparam int unsigned B_TRAP_G0   = 11;
  localparam int unsigned B_TRAP_G1   = 12;
  localparam int unsigned B_TRAP_DEAC = 14;

  // storable bits: count, four trap bits, eight interrupt controls
  localparam logic [CTRL_W-1:0] WR_MASK = 32'hF800_5CFF;

  typedef struct packed {
    logic underflow;
    logic cnt_nz;
    logic nopend;
    logic g0_on;
    logic g0_off;
    logic g1_on;
    logic g1_off;
  } cond_t;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + CNT_W'(1);
  endfunction

  function automatic logic [CTRL_W-1:0] masked_write(input logic [CTRL_W-1:0] d);
    return d & WR_MASK;
  endfunction
endpackage

// File: rtl/vmaint_ctrl_reg.sv
module vmaint_ctrl_reg
  import vmaint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              deact_pulse,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              cnt_bump,
  output logic              cnt_at_max
);
  logic [CNT_W-1:0] cnt_cur;

  assign cnt_cur    = ctrl_q[CNT_MSB:CNT_LSB];
  assign cnt_at_max = &cnt_cur;
  // a pulse only counts when no write owns the field this cycle
  assign cnt_bump   = deact_pulse && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= masked_write(wr_data);
    end else if (cnt_bump) begin
      ctrl_q[CNT_MSB:CNT_LSB] <= sat_inc(cnt_cur);
    end
  end
endmodule

// File: rtl/vmaint_entry_stats.sv
module vmaint_entry_stats #(
  parameter int unsigned N_ENTRIES = 4,
  localparam int unsigned CW = $clog2(N_ENTRIES + 1)
) (
  input  logic [N_ENTRIES-1:0] entry_valid,
  input  logic [N_ENTRIES-1:0] entry_pending,
  output logic [CW-1:0]        valid_cnt,
  output logic                 few_valid,
  output logic                 none_pending
);
  always_comb begin
    valid_cnt = '0;
    for (int i = 0; i < int'(N_ENTRIES); i++) begin
      valid_cnt = valid_cnt + CW'(entry_valid[i]);
    end
  end

  assign few_valid    = (valid_cnt <= CW'(1));
  assign none_pending = ~|entry_pending;
endmodule

// File: rtl/vmaint_irq_merge.sv
module vmaint_irq_merge
  import vmaint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              few_valid,
  input  logic              none_pending,
  input  logic              vgrp0_en,
  input  logic              vgrp1_en,
  output cond_t             hits,
  output logic              irq_next,
  output logic              maint_irq
);
  logic cnt_nonzero;
  assign cnt_nonzero = |ctrl_q[CNT_MSB:CNT_LSB];

  always_comb begin
    hits.underflow = ctrl_q[B_UNDERFLOW] && few_valid;
    hits.cnt_nz    = ctrl_q[B_CNT_NZ]    && cnt_nonzero;
    hits.nopend    = ctrl_q[B_NOPEND]    && none_pending;
    hits.g0_on     = ctrl_q[B_G0_ON]     &&  vgrp0_en;
    hits.g0_off    = ctrl_q[B_G0_OFF]    && !vgrp0_en;
    hits.g1_on     = ctrl_q[B_G1_ON]     &&  vgrp1_en;
    hits.g1_off    = ctrl_q[B_G1_OFF]    && !vgrp1_en;
  end

  assign irq_next = ctrl_q[B_EN] && (|hits);

  always_ff @(posedge clk) begin
    if (!rst_n) maint_irq <= 1'b0;
    else        maint_irq <= irq_next;
  end
endmodule

// File: rtl/vmaint_gen.sv
module vmaint_gen
  import vmaint_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic [N_ENTRIES-1:0] entry_valid,
  input  logic [N_ENTRIES-1:0] entry_pending,
  input  logic                 vgrp0_en,
  input  logic                 vgrp1_en,
  input  logic                 deact_pulse,
  output logic                 maint_irq,
  output logic                 trap_common,
  output logic                 trap_grp0,
  output logic                 trap_grp1,
  output logic                 trap_deact
);
  localparam int unsigned CW = $clog2(N_ENTRIES + 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic              cnt_bump;
  logic              cnt_at_max;
  logic [CW-1:0]     valid_cnt;
  logic              few_valid;
  logic              none_pending;
  cond_t             hits;
  logic              irq_next;

  vmaint_ctrl_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .deact_pulse (deact_pulse),
    .ctrl_q      (ctrl_q),
    .cnt_bump    (cnt_bump),
    .cnt_at_max  (cnt_at_max)
  );

  vmaint_entry_stats #(.N_ENTRIES(N_ENTRIES)) u_stats (
    .entry_valid   (entry_valid),
    .entry_pending (entry_pending),
    .valid_cnt     (valid_cnt),
    .few_valid     (few_valid),
    .none_pending  (none_pending)
  );

  vmaint_irq_merge u_merge (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_q       (ctrl_q),
    .few_valid    (few_valid),
    .none_pending (none_pending),
    .vgrp0_en     (vgrp0_en),
    .vgrp1_en     (vgrp1_en),
    .hits         (hits),
    .irq_next     (irq_next),
    .maint_irq    (maint_irq)
  );

  assign rd_data     = ctrl_q;
  assign trap_common = ctrl_q[B_TRAP_CMN];
  assign trap_grp0   = ctrl_q[B_TRAP_G0];
  assign trap_grp1   = ctrl_q[B_TRAP_G1];
  assign trap_deact  = ctrl_q[B_TRAP_DEAC];
endmodule

// File: rtl/vmaint_gen_chk.sv
module vmaint_gen_chk
  import vmaint_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [31:0]          wr_data,
  input logic [31:0]          rd_data,
  input logic [N_ENTRIES-1:0] entry_valid,
  input logic                 deact_pulse,
  input logic                 maint_irq,
  input logic                 irq_next,
  input logic                 cnt_bump
);
  // R2 reserved bits stay clear after any write
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[26:15] == '0 && rd_data[13] == 1'b0 && rd_data[9:8] == '0));

  // R9 a write always lands exactly, with or without a pulse
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == ($past(wr_data) & WR_MASK)));

  // R8 increment below saturation
  a_r8_count_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_pulse && !wr_en && rd_data[31:27] != 5'd31)
      |=> (rd_data[31:27] == $past(rd_data[31:27]) + 5'd1));

  // R8 saturation hold
  a_r8_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_pulse && !wr_en && rd_data[31:27] == 5'd31) |=> (rd_data[31:27] == 5'd31));

  // R9 a colliding pulse is not taken as an increment
  a_r9_no_bump_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cnt_bump);

  // R3 global enable low silences the output next cycle
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |=> !maint_irq);

  // R3 output is the registered merge result
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (maint_irq == $past(irq_next)));

  // R4 underflow raises the output
  a_r4_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && rd_data[1] && $countones(entry_valid) <= 1) |=> maint_irq);
endmodule

bind vmaint_gen vmaint_gen_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .entry_valid (entry_valid),
  .deact_pulse (deact_pulse),
  .maint_irq   (maint_irq),
  .irq_next    (irq_next),
  .cnt_bump    (cnt_bump)
);

// File: tb/test_vmaint_gen.sv
`timescale 1ns/1ps
module test_vmaint_gen;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [31:0]  wr_data = '0;
  logic [31:0]  rd_data;
  logic [N-1:0] entry_valid = '0;
  logic [N-1:0] entry_pending = '0;
  logic         vgrp0_en = 1'b0;
  logic         vgrp1_en = 1'b0;
  logic         deact_pulse = 1'b0;
  logic         maint_irq;
  logic         trap_common, trap_grp0, trap_grp1, trap_deact;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  vmaint_gen #(.N_ENTRIES(N)) i_vmaint_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .entry_valid(entry_valid), .entry_pending(entry_pending),
    .vgrp0_en(vgrp0_en), .vgrp1_en(vgrp1_en), .deact_pulse(deact_pulse),
    .maint_irq(maint_irq), .trap_common(trap_common), .trap_grp0(trap_grp0),
    .trap_grp1(trap_grp1), .trap_deact(trap_deact)
  );

  // reference model: integers, behavioural
  int unsigned m_word = 0;
  bit          m_irq  = 0;

  always @(posedge clk) begin
    int nvalid;
    int cnt;
    bit any;
    if (!rst_n) begin
      m_word = 0;
      m_irq  = 0;
    end else begin
      nvalid = 0;
      for (int i = 0; i < N; i++) if (entry_valid[i]) nvalid++;
      cnt = int'(m_word >> 27);
      any = 0;
      if (m_word[1] && nvalid < 2)          any = 1;
      if (m_word[2] && cnt != 0)            any = 1;
      if (m_word[3] && entry_pending == 0)  any = 1;
      if (m_word[4] && vgrp0_en)            any = 1;
      if (m_word[5] && !vgrp0_en)           any = 1;
      if (m_word[6] && vgrp1_en)            any = 1;
      if (m_word[7] && !vgrp1_en)           any = 1;
      m_irq = m_word[0] && any;
      if (wr_en) begin
        m_word = 0;
        for (int b = 0; b < 32; b++) begin
          if (wr_data[b] && (b <= 7 || b == 10 || b == 11 || b == 12 || b == 14 || b >= 27))
            m_word[b] = 1'b1;
        end
      end else if (deact_pulse && cnt < 31) begin
        m_word = m_word + (32'd1 << 27);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  task automatic step();
    @(posedge clk);
    #1;
    if (rst_n) begin
      check({phase, " rd_data"}, rd_data, m_word);
      check({phase, " maint_irq R3"}, 32'(maint_irq), 32'(m_irq));
      check("R10 traps", {28'd0, trap_deact, trap_grp1, trap_grp0, trap_common},
            {28'd0, m_word[14], m_word[12], m_word[11], m_word[10]});
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 maint_irq", 32'(maint_irq), 32'h0);

    // R2 masking of reserved bits
    phase = "R2";
    wr(32'hFFFF_FFFF);
    check("R2 masked write", rd_data, 32'hF800_5CFF);
    // R10 trap outputs all high
    check("R10 all traps", {28'd0, trap_deact, trap_grp1, trap_grp0, trap_common}, 32'hF);
    wr(32'h0000_4000);
    check("R10 only deact trap", {28'd0, trap_deact, trap_grp1, trap_grp0, trap_common}, 32'h8);

    // R4 underflow with varying valid counts
    phase = "R4";
    entry_pending = 4'hF;
    wr(32'h0000_0003);
    entry_valid = 4'b0000; step(); step();
    check("R4 zero valid", 32'(maint_irq), 32'h1);
    entry_valid = 4'b0100; step(); step();
    check("R4 one valid", 32'(maint_irq), 32'h1);
    entry_valid = 4'b0110; step(); step();
    check("R4 two valid", 32'(maint_irq), 32'h0);
    entry_valid = 4'b1111; step();

    // R5 count nonzero; pulse raises count then interrupt one cycle later
    phase = "R5";
    wr(32'h0000_0005);
    step();
    check("R5 count zero", 32'(maint_irq), 32'h0);
    deact_pulse = 1'b1; step(); deact_pulse = 1'b0;
    check("R5 count one", rd_data, 32'h0800_0005);
    step();
    check("R5 irq after pulse", 32'(maint_irq), 32'h1);

    // R8 saturation
    phase = "R8";
    deact_pulse = 1'b1;
    repeat (40) step();
    deact_pulse = 1'b0;
    check("R8 saturated", 32'(rd_data[31:27]), 32'd31);

    // R9 collisions: write zero count at saturation, then nonzero write value
    phase = "R9";
    deact_pulse = 1'b1; wr(32'h0000_0001); deact_pulse = 1'b0;
    check("R9 clear wins", rd_data, 32'h0000_0001);
    deact_pulse = 1'b1; wr(32'h1800_0005); deact_pulse = 1'b0;
    check("R9 load wins", rd_data, 32'h1800_0005);
    step();
    wr(32'h0000_0000);

    // R6 no-pending condition
    phase = "R6";
    wr(32'h0000_0009);
    entry_pending = 4'b0010; step(); step();
    check("R6 some pending", 32'(maint_irq), 32'h0);
    entry_pending = 4'b0000; step(); step();
    check("R6 none pending", 32'(maint_irq), 32'h1);
    entry_pending = 4'hF;

    // R7 group conditions, each bit alone
    phase = "R7";
    for (int k = 4; k < 8; k++) begin
      wr(32'h1 | (32'h1 << k));
      for (int g = 0; g < 4; g++) begin
        vgrp0_en = g[0]; vgrp1_en = g[1];
        step(); step();
      end
    end
    wr(32'h0000_0021); vgrp0_en = 1'b0; step(); step();
    check("R7 group0 off", 32'(maint_irq), 32'h1);
    wr(32'h0000_0041); vgrp1_en = 1'b1; step(); step();
    check("R7 group1 on", 32'(maint_irq), 32'h1);

    // R3 global enable low with every condition enabled
    phase = "R3";
    entry_valid = 4'b0000; entry_pending = 4'b0000;
    wr(32'h0800_00FE); step(); step();
    check("R3 disabled quiet", 32'(maint_irq), 32'h0);
    wr(32'h0800_00FF);
    check("R3 latency edge", 32'(maint_irq), 32'h0);
    step();
    check("R3 enabled fires", 32'(maint_irq), 32'h1);

    // mixed stimulus, model compared each cycle
    phase = "R3/R8/R9";
    for (int c = 0; c < 600; c++) begin
      entry_valid   = N'($urandom);
      entry_pending = N'($urandom);
      vgrp0_en      = 1'($urandom);
      vgrp1_en      = 1'($urandom);
      deact_pulse   = ($urandom % 3) == 0;
      wr_en         = ($urandom % 8) == 0;
      wr_data       = $urandom & 32'h07FF_FFFF | (($urandom % 4 == 0) ? 32'h0 : $urandom);
      step();
    end
    wr_en = 1'b0; deact_pulse = 1'b0;
    step();
    finish_run();
  end
endmodule